// File: doc/BRIEF.md
# Two-Interval Countdown Timer

This block is a countdown timer that a controlling state machine steers with a 2-bit command. In a single cycle the command can arm the timer with either a long or a short preset interval. A separate run code, held for as long as the count should proceed, then counts down. A stop code freezes the timer. One flag, `done`, reports that the armed interval has run out. The flag is sticky: it stays high until the next load.

The time base comes from one of two sources. If the prescaler parameter is zero, each high cycle of the external `tick_in` input is one time unit. Otherwise an internal divider produces one time unit every `PRESCALE_DIV` clocks and `tick_in` is ignored. Both interval lengths are parameters counted in time units, so a simulation can use small values where hardware would use counts of seconds.

Top module: `interval_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done` reads 0 until an interval runs out.
- R2: Command 2'b01 loads the long interval (`LONG_TICKS` time units) and clears `done` at the next clock edge, regardless of any tick in that cycle.
- R3: Command 2'b10 loads the short interval (`SHORT_TICKS` time units) and clears `done` at the next clock edge, regardless of any tick in that cycle.
- R4: Command 2'b11 in a cycle that carries a time unit takes one unit off the count. After a load of N units, `done` rises at the clock edge of the N-th such cycle and not earlier.
- R5: Command 2'b11 in a cycle without a time unit changes neither the count nor `done`.
- R6: Command 2'b00 holds the count and `done` whether or not a time unit is present. The stopped cycles do not shorten the time left.
- R7: Once set, `done` stays 1 under any run or stop commands, with or without time units, until a load command clears it. The count stays at zero meanwhile.
- R8: A run cycle with a time unit while the count is already zero (for example right after reset) sets `done` at that edge.
- R9: With `PRESCALE_DIV` > 0, a time unit occurs in the clock cycle just before every `PRESCALE_DIV`-th edge counted from reset release (every cycle when the value is 1), and `tick_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 00 stop, 01 load long, 10 load short, 11 run |
| tick_in | input | 1 | External time-unit strobe, used when `PRESCALE_DIV` is 0 |
| done | output | 1 | Sticky flag: the loaded interval has run out |

## Verification
Two events can fall in the same cycle: a load command and a time unit. The bench provokes this by pulsing `tick_in` exactly in load cycles, including a reload right after expiry. It expects the load to win: the full interval is counted afresh and `done` drops. Runs of stop and tick-less run cycles are interleaved with counting, and a pseudo-random command stream follows. On every clock, `done` is compared with a behavioural model, both for the external-tick instance and for a second instance driven by the internal divider.

// File: rtl/itv_pkg.sv
package itv_pkg;

  typedef enum logic [1:0] {
    CMD_HALT       = 2'b00,
    CMD_LOAD_LONG  = 2'b01,
    CMD_LOAD_SHORT = 2'b10,
    CMD_RUN        = 2'b11
  } itv_cmd_e;

  typedef struct packed {
    logic halt;
    logic load_long;
    logic load_short;
    logic run;
  } itv_dec_t;

  function automatic itv_dec_t itv_decode(input logic [1:0] code);
    itv_dec_t d;
    d.halt       = (code == CMD_HALT);
    d.load_long  = (code == CMD_LOAD_LONG);
    d.load_short = (code == CMD_LOAD_SHORT);
    d.run        = (code == CMD_RUN);
    return d;
  endfunction

endpackage

// File: rtl/itv_tick_gen.sv
module itv_tick_gen #(
  parameter int PRESCALE_DIV = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick
);

  generate
    if (PRESCALE_DIV == 0) begin : g_external
      wire unused_clkrst = clk ^ rst_n;
      assign tick = tick_in;
    end else begin : g_divider
      localparam int PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
      localparam logic [PW-1:0] LAST = PW'(PRESCALE_DIV - 1);
      logic [PW-1:0] phase_q;
      wire unused_tick_in = tick_in;

      assign tick = (phase_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + PW'(1);
      end

      if (PRESCALE_DIV > 1) begin : g_chk
        // R9: divided time units are single-cycle strobes
        a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
          tick |=> !tick);
      end
    end
  endgenerate

endmodule

// File: rtl/itv_counter.sv
module itv_counter
  import itv_pkg::*;
#(
  parameter int LONG_TICKS  = 30,
  parameter int SHORT_TICKS = 3,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_TICKS);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_TICKS);

  function automatic logic [CNT_W-1:0] count_after_unit(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(1)) ? c - CNT_W'(1) : '0;
  endfunction

  function automatic logic unit_finishes(input logic [CNT_W-1:0] c);
    return (c <= CNT_W'(1));
  endfunction

  itv_dec_t         dec;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             ev_load, ev_step, ev_expire;

  assign dec       = itv_decode(cmd);
  assign ev_load   = dec.load_long | dec.load_short;
  assign ev_step   = dec.run & tick;
  assign ev_expire = ev_step & unit_finishes(cnt_q);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (dec.load_long) begin
      cnt_d  = LONG_V;
      done_d = 1'b0;
    end else if (dec.load_short) begin
      cnt_d  = SHORT_V;
      done_d = 1'b0;
    end else if (ev_step) begin
      cnt_d = count_after_unit(cnt_q);
      if (ev_expire) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  // R2
  a_r2_load_long: assert property (@(posedge clk) disable iff (!rst_n)
    dec.load_long |=> (cnt_q == LONG_V) && !done_q);
  // R3
  a_r3_load_short: assert property (@(posedge clk) disable iff (!rst_n)
    dec.load_short |=> (cnt_q == SHORT_V) && !done_q);
  // R4
  a_r4_one_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && $stable(done_q));
  // R5
  a_r5_run_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.run && !tick) |=> $stable(cnt_q) && $stable(done_q));
  // R6
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dec.halt |=> $stable(cnt_q) && $stable(done_q));
  // R7
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ev_load) |=> done_q);
  a_r7_zero_while_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0));
  // R8
  a_r8_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && cnt_q == '0) |=> done_q);

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int LONG_TICKS   = 30,
  parameter int SHORT_TICKS  = 3,
  parameter int PRESCALE_DIV = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  input  logic       tick_in,
  output logic       done
);

  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             unit_tick;
  logic [CNT_W-1:0] count;

  itv_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .tick    (unit_tick)
  );

  itv_counter #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .CNT_W      (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .tick   (unit_tick),
    .cnt_o  (count),
    .done_o (done)
  );

  // R1: flag low during reset
  always_comb begin
    if (!rst_n) a_r1_reset_low: assert (done == 1'b0 || $isunknown(done));
  end

  // R7: flag high only with an empty count
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == '0));

endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;

  localparam int LONG_A  = 12;
  localparam int SHORT_A = 3;
  localparam int LONG_B  = 5;
  localparam int SHORT_B = 2;
  localparam int DIV_B   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       tick = 1'b0;
  logic       done_a, done_b;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  interval_timer #(.LONG_TICKS(LONG_A), .SHORT_TICKS(SHORT_A), .PRESCALE_DIV(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick_in(tick), .done(done_a));

  interval_timer #(.LONG_TICKS(LONG_B), .SHORT_TICKS(SHORT_B), .PRESCALE_DIV(DIV_B)) u_dut_div (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick_in(tick), .done(done_b));

  // behavioural reference: time left and flag for each instance
  int m_left[2] = '{0, 0};
  int m_flag[2] = '{0, 0};
  int m_phase = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = '{0, 0};
      m_flag = '{0, 0};
      m_phase = 0;
    end else begin
      bit unit_b;
      unit_b = (m_phase == DIV_B - 1);
      m_phase = unit_b ? 0 : m_phase + 1;
      for (int k = 0; k < 2; k++) begin
        bit unit;
        unit = (k == 0) ? tick : unit_b;
        if (cmd == 2'b01) begin
          m_left[k] = (k == 0) ? LONG_A : LONG_B;
          m_flag[k] = 0;
        end else if (cmd == 2'b10) begin
          m_left[k] = (k == 0) ? SHORT_A : SHORT_B;
          m_flag[k] = 0;
        end else if (cmd == 2'b11 && unit) begin
          if (m_left[k] > 0) m_left[k] = m_left[k] - 1;
          if (m_left[k] == 0) m_flag[k] = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: done=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(cur_req, done_a, m_flag[0] != 0);
    chk("R9", done_b, m_flag[1] != 0);
  end

  task automatic step(input logic [1:0] c, input logic t);
    @(negedge clk);
    #0.5;
    cmd = c;
    tick = t;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", done_a, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 1'b0);
    chk("R1", done_a, 1'b0);

    // R3: short load, then counting down
    cur_req = "R3";
    step(2'b10, 1'b1);
    chk("R3", done_a, 1'b0);
    cur_req = "R4";
    step(2'b11, 1'b1);
    step(2'b11, 1'b1);
    chk("R4", done_a, 1'b0);
    step(2'b11, 1'b1);
    chk("R4", done_a, 1'b1);

    // R7: sticky under run and stop
    cur_req = "R7";
    for (int i = 0; i < 6; i++) step((i % 2) ? 2'b00 : 2'b11, 1'b1);
    chk("R7", done_a, 1'b1);

    // R2: long load with a simultaneous tick
    cur_req = "R2";
    step(2'b01, 1'b1);
    chk("R2", done_a, 1'b0);
    cur_req = "R5";
    for (int i = 0; i < 11; i++) begin
      step(2'b11, 1'b1);
      step(2'b11, 1'b0);
      step(2'b00, 1'b1);
    end
    chk("R6", done_a, 1'b0);
    step(2'b00, 1'b1);
    step(2'b11, 1'b0);
    chk("R5", done_a, 1'b0);
    step(2'b11, 1'b1);
    chk("R4", done_a, 1'b1);

    // R3: reload right after expiry, tick in the load cycle
    cur_req = "R3";
    step(2'b10, 1'b1);
    chk("R3", done_a, 1'b0);
    step(2'b11, 1'b1);
    step(2'b11, 1'b1);
    chk("R6", done_a, 1'b0);

    // R8: run from an empty count after reset
    cur_req = "R8";
    @(negedge clk);
    #1 rst_n = 1'b0;
    step(2'b00, 1'b0);
    chk("R1", done_a, 1'b0);
    @(negedge clk);
    #0.5 rst_n = 1'b1;
    step(2'b11, 1'b0);
    chk("R8", done_a, 1'b0);
    step(2'b11, 1'b1);
    chk("R8", done_a, 1'b1);

    // mixed stream against the model
    cur_req = "R6";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      logic [1:0] c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0)      c = 2'b01;
      else if (lfsr[3:0] == 4'd1) c = 2'b10;
      else if (lfsr[3:0] < 4'd4)  c = 2'b00;
      else                        c = 2'b11;
      step(c, lfsr[6] | lfsr[9]);
    end

    @(negedge clk);
    #1;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule